// File: doc/BRIEF.md
# Table-Driven Reflected CRC Engine

This block computes a right-shifting (reflected) cyclic redundancy check of up to 32 bits over a stream of bytes. The polynomial is not wired into the logic. Before a run, software or a test harness loads a 16-entry, 32-bit lookup table through a write port, so any polynomial of order 32 or less can be used. The table is the 4-bit-step remainder image of that polynomial.

A run begins with a start pulse. The pulse supplies a 32-bit seed and a 16-bit byte count. Bytes then arrive on a valid/ready stream. Each accepted byte is XORed into the low eight bits of the running value and folded in with two nibble lookups, one per clock cycle. When the last byte has been folded, a one-cycle done strobe marks the 32-bit result.

A shorter CRC sits in the low-order bits of the result. A message split into pieces can be chained by passing each result in as the seed of the next run.

Top module: `nibcrc_unit`

## Requirements
- R1: While the unit is idle, a write with `tbl_we` high stores `tbl_wdata` into the table entry selected by `tbl_addr`, and later runs use that entry.
- R2: While a run is in progress (`busy` high), table writes are ignored, and the result of the run and of later runs is unchanged.
- R3: `start` is acted on only while the unit is idle. It captures `init_crc` as the running value and `byte_cnt` as the number of bytes to fold. A `start` while busy has no effect.
- R4: Each accepted byte is XORed into bits 7:0 of the running value. Then two steps are applied, each of the form value = (value >> 4) XOR table[value[3:0]]. With a table built from a reflected polynomial, this equals eight single-bit steps of "shift right with zero fill, XOR in the polynomial when the bit shifted out was 1".
- R5: `in_ready` is high only while the unit waits for a byte. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low in the cycle after an acceptance, so each byte takes two cycles.
- R6: A byte count of zero raises `done` in the cycle after `start`, with `crc_out` equal to `init_crc`.
- R7: `done` is high for exactly one cycle, in the cycle after the final step of the last byte. `crc_out` then holds the result until the next accepted `start`.
- R8: Running a message in two pieces, with the first result as the second seed, gives the same result as one run over the whole message.
- R9: Byte counts up to 65535 are handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Table entry index |
| tbl_wdata | input | 32 | Table entry data |
| start | input | 1 | Begin a run |
| init_crc | input | 32 | Seed value for the run |
| byte_cnt | input | 16 | Number of bytes in the run |
| in_valid | input | 1 | Byte available |
| in_data | input | 8 | Byte value |
| in_ready | output | 1 | Unit accepts a byte this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle strobe, result valid |
| crc_out | output | 32 | Running value and final result |

## Verification
The bench builds tables for a 32-bit and a 16-bit reflected polynomial. It checks every run against a bit-serial reference, so a wrong nibble index, a byte XORed into the wrong bits, or a swapped step order shows up as a miscompare. Directed cases cover:
- A zero-length run, which a design would break by skipping the strobe or by altering the seed.
- A table write during a run, which a design that does not lock the table would let corrupt the result.
- A second start during a run, which would reload the seed mid-stream.
- A run split into two chained pieces.
- A 65535-byte run, which a counter that is too narrow or off by one would end early or late.

Throughout, random gaps in `in_valid` test that bytes are taken only on handshakes.

// File: rtl/nibcrc_pkg.sv
package nibcrc_pkg;
  localparam int CRC_W  = 32;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } nib_state_t;
endpackage

// File: rtl/nibcrc_table.sv
module nibcrc_table #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          lock,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int N = 1 << AW;

  logic [N-1:0][W-1:0] mem_q;
  logic                wr_ok;

  assign wr_ok = wr_en & ~lock;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic hit;
    assign hit = wr_ok && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R2: no table entry moves while a run holds the lock
  p_table_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mem_q));
  // R1: an unlocked write lands in the addressed entry
  p_table_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock) |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/nibcrc_step.sv
module nibcrc_step #(
  parameter int W  = 32,
  parameter int AW = 4,
  parameter int BW = 8
) (
  input  logic [W-1:0]  crc_i,
  input  logic [BW-1:0] byte_i,
  input  logic          fold_i,
  output logic [AW-1:0] idx_o,
  input  logic [W-1:0]  entry_i,
  output logic [W-1:0]  crc_o
);
  logic [W-1:0] mixed;

  always_comb begin
    mixed = crc_i;
    if (fold_i) mixed = crc_i ^ W'(byte_i);
    idx_o = mixed[AW-1:0];
    crc_o = (mixed >> AW) ^ entry_i;
  end
endmodule

// File: rtl/nibcrc_ctrl.sv
module nibcrc_ctrl
  import nibcrc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          adv_o,
  output logic          fold_o
);
  nib_state_t    state_q, state_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          rem_en;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    fold_o  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        rem_en  = 1'b1;
        rem_d   = cnt_i;
        state_d = (cnt_i == '0) ? ST_FIN : ST_LO;
      end
      ST_LO: if (in_valid_i) begin
        adv_o   = 1'b1;
        fold_o  = 1'b1;
        state_d = ST_HI;
      end
      ST_HI: begin
        adv_o   = 1'b1;
        rem_en  = 1'b1;
        rem_d   = rem_q - CW'(1);
        state_d = (rem_q == CW'(1)) ? ST_FIN : ST_LO;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign in_ready_o = (state_q == ST_LO);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);

  // R7: strobe lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: second nibble step follows every acceptance, no new byte taken
  p_two_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> (!in_ready_o && adv_o && !fold_o));
  // R6: empty run finishes at once
  p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && cnt_i == '0) |=> done_o);
  // R5: ready never outside a run
  p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> busy_o);
endmodule

// File: rtl/nibcrc_unit.sv
module nibcrc_unit
  import nibcrc_pkg::*;
#(
  parameter int W  = CRC_W,
  parameter int AW = NIB_W,
  parameter int BW = BYTE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [W-1:0]  tbl_wdata,
  input  logic          start,
  input  logic [W-1:0]  init_crc,
  input  logic [CW-1:0] byte_cnt,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  output logic          in_ready,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  crc_out
);
  logic          load, adv, fold;
  logic [AW-1:0] idx;
  logic [W-1:0]  entry, step_crc;
  logic [W-1:0]  crc_q, crc_d;
  logic          crc_en;

  nibcrc_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cnt_i(byte_cnt),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .busy_o(busy),
    .done_o(done), .load_o(load), .adv_o(adv), .fold_o(fold)
  );

  nibcrc_table #(.W(W), .AW(AW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .lock(busy),
    .wr_addr(tbl_addr), .wr_data(tbl_wdata), .rd_addr(idx), .rd_data(entry)
  );

  nibcrc_step #(.W(W), .AW(AW), .BW(BW)) u_step (
    .crc_i(crc_q), .byte_i(in_data), .fold_i(fold), .idx_o(idx),
    .entry_i(entry), .crc_o(step_crc)
  );

  always_comb begin
    crc_en = load | adv;
    crc_d  = load ? init_crc : step_crc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_out = crc_q;

  // R6: empty run returns the seed
  p_zero_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && byte_cnt == '0) |=> (crc_out == $past(init_crc)));
  // R7: result held while idle with no start
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(crc_out));
  // R3: start while busy does not reload the running value
  p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !in_ready && !done) |=> (crc_out == $past(step_crc)));
endmodule

// File: tb/nibcrc_unit_test.sv
module nibcrc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [3:0]  tbl_addr;
  logic [31:0] tbl_wdata;
  logic        start;
  logic [31:0] init_crc;
  logic [15:0] byte_cnt;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready, busy, done;
  logic [31:0] crc_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] cur_poly;
  logic [7:0]  dbuf [0:65535];

  always #10 clk = ~clk;

  nibcrc_unit uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .start(start), .init_crc(init_crc),
    .byte_cnt(byte_cnt), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .busy(busy), .done(done), .crc_out(crc_out)
  );

  function automatic logic [31:0] bit_steps(logic [31:0] c, int n, logic [31:0] p);
    for (int k = 0; k < n; k++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] ref_crc(logic [31:0] c, int first, int n, logic [31:0] p);
    for (int k = 0; k < n; k++) c = bit_steps(c ^ {24'd0, dbuf[first+k]}, 8, p);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic load_table(input logic [31:0] p);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 4'(i); tbl_wdata = bit_steps(32'(i), 4, p);
    end
    @(negedge clk);
    tbl_we = 1'b0;
    cur_poly = p;
  endtask

  // run over dbuf[first +: n]; mode 1 = table write mid-run, 2 = start mid-run
  task automatic run(input logic [31:0] seed, input int first, input int n,
                     input bit gaps, input int mode, input string req,
                     output logic [31:0] res);
    logic [31:0] exp;
    int i, t;
    bit took;
    exp = ref_crc(seed, first, n, cur_poly);
    @(negedge clk);
    start = 1'b1; init_crc = seed; byte_cnt = 16'(n);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done === 1'b1, "R6 done after start", {31'd0, done}, 32'd1);
      chk(crc_out === seed, "R6 seed returned", crc_out, seed);
      res = crc_out;
      @(negedge clk);
      chk(done === 1'b0, "R7 single strobe", {31'd0, done}, 32'd0);
      return;
    end
    i = 0;
    t = 0;
    while (i < n) begin
      bit gap;
      gap = gaps && ($urandom % 4 == 0);
      in_valid = !gap;
      in_data = dbuf[first+i];
      took = !gap && in_ready;
      if (took) i++;
      if (t == 0 && mode == 1) begin
        tbl_we = 1'b1; tbl_addr = dbuf[first][3:0] ^ seed[3:0]; tbl_wdata = 32'hDEAD_BEEF;
      end
      if (t == 0 && mode == 2) begin
        start = 1'b1; init_crc = ~seed; byte_cnt = 16'd3;
      end
      @(negedge clk);
      tbl_we = 1'b0; start = 1'b0;
      if (t == 0 && took)
        chk(in_ready === 1'b0, "R5 ready low after accept", {31'd0, in_ready}, 32'd0);
      t++;
    end
    in_valid = 1'b0;
    t = 0;
    while (done !== 1'b1 && t < 8) begin @(negedge clk); t++; end
    chk(done === 1'b1 && crc_out === exp, req, crc_out, exp);
    res = crc_out;
    @(negedge clk);
    chk(done === 1'b0 && crc_out === exp, "R7 strobe ends, result held", crc_out, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, r1, r2;
    void'($urandom(32'd1234));
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    start = 1'b0; init_crc = '0; byte_cnt = '0; in_valid = 1'b0; in_data = '0;
    cur_poly = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !in_ready && crc_out === 32'd0, "reset state",
        {busy, done, in_ready, 29'd0} | crc_out, 32'd0);
    rst_n = 1'b1;

    // R1/R4: 32-bit polynomial, known string "123456789"
    load_table(32'hEDB8_8320);
    for (int k = 0; k < 9; k++) dbuf[k] = 8'h31 + 8'(k);
    run(32'hFFFF_FFFF, 0, 9, 1'b0, 0, "R4 check string", r);
    chk(~r === 32'hCBF4_3926, "R4 standard check value", ~r, 32'hCBF4_3926);

    // R6: zero length
    run(32'h1234_5678, 0, 0, 1'b0, 0, "R6", r);

    // R4/R5: random runs with gaps
    for (int j = 0; j < 20; j++) begin
      int n;
      n = 1 + int'($urandom % 40);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      run($urandom, 0, n, 1'b1, 0, "R4 random run", r);
    end

    // R2: table write during a run ignored, then next run still clean
    for (int k = 0; k < 12; k++) dbuf[k] = 8'($urandom);
    run(32'hA5A5_0F0F, 0, 12, 1'b0, 1, "R2 write during run", r);
    run(32'h0000_0000, 0, 12, 1'b1, 0, "R2 table intact afterwards", r);

    // R3: start during a run ignored
    run(32'h5555_AAAA, 0, 12, 1'b0, 2, "R3 start while busy", r);

    // R8: chaining
    for (int k = 0; k < 30; k++) dbuf[k] = 8'($urandom);
    run(32'hFFFF_FFFF, 0, 30, 1'b1, 0, "R8 whole message", r);
    run(32'hFFFF_FFFF, 0, 11, 1'b1, 0, "R8 first piece", r1);
    run(r1, 11, 19, 1'b1, 0, "R8 second piece", r2);
    chk(r2 === r, "R8 chained equals whole", r2, r);

    // R1: reload with a 16-bit reflected polynomial
    load_table(32'h0000_A001);
    for (int k = 0; k < 9; k++) dbuf[k] = 8'h31 + 8'(k);
    run(32'h0000_0000, 0, 9, 1'b0, 0, "R1 new table", r);
    chk(r === 32'h0000_BB3D, "R1 16-bit result in low bits", r, 32'h0000_BB3D);

    // R9: maximum byte count
    load_table(32'hEDB8_8320);
    for (int k = 0; k < 65535; k++) dbuf[k] = 8'($urandom);
    run(32'hFFFF_FFFF, 0, 65535, 1'b0, 0, "R9 maximum count", r);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule